// File: doc/BRIEF.md
# Prescaled Interval Timer

A multi-channel interval timer peripheral. Each channel owns a control word, a compare value and a live 24-bit down-counter. An 8-bit divide value in the control word sets how many input clocks make up one counting step. Software loads the compare value, then raises the channel's enable bit; the counter starts from the compare value and steps down once per divided tick. When a tick arrives while the count already sits at zero, the channel expires. It then raises its flag in a shared status word and either reloads and keeps running (periodic) or halts (one-shot).

Software reaches the block through a simple synchronous word port. A write lands on the clock edge where it is sampled. A read returns its data one cycle later, from a registered output. Each channel drives an interrupt output that is its status flag gated by its interrupt-enable bit, and one combined line ORs all channel interrupts together. Status flags are cleared by writing ones to the status word.

The register map uses word addresses. Channel `n` has its control word at `4n`, its compare value at `4n+1` and its count at `4n+2`. The status word sits at `4*NUM_CH`, which is address 8 with two channels.

Top module: `ptimer_top`

## Requirements
- R1: After reset, every control word, compare value, count and status flag reads 0, and `chan_irq` and `irq_any` are low.
- R2: In a control word, bit 30 is enable, bit 29 is interrupt enable, bits 28:27 are the mode and bits 7:0 are the divide value. Mode 01 is periodic and every other mode value is one-shot. These fields read back at the same positions, and all other bits read 0.
- R3: The compare value and the count are 24 bits wide; bits 31:24 of a compare write are dropped and read 0.
- R4: A control write that takes enable from 0 to 1 loads the count from the compare value and restarts the divider. After that, the count steps down by one on every (divide + 1)-th clock edge after the write edge.
- R5: A channel expires on a divided tick that finds the count at 0. The first expiry falls (compare + 1) × (divide + 1) clock edges after the starting write edge. Expiry sets status bit n for channel n, whatever interrupt enable is set to.
- R6: In periodic mode, expiry reloads the compare value, and the channel keeps counting and expires again every (compare + 1) × (divide + 1) edges.
- R7: In one-shot mode, expiry clears the enable bit and the count stays at 0, so the channel fires exactly once.
- R8: A control write with enable 0 stops the channel, and the count then holds its value.
- R9: Writing 1 to a status bit clears that flag and writing 0 leaves it unchanged. If an expiry and a clear of the same flag fall on the same edge, the flag stays set.
- R10: `chan_irq[n]` is flag n ANDed with channel n's interrupt enable, and `irq_any` is the OR of all `chan_irq` bits. Setting interrupt enable while a flag is pending raises the output at once.
- R11: Read data is registered: a read sampled on edge m shows, from edge m onward, the register value held just before edge m. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| chan_irq | output | NUM_CH | Per-channel interrupt (flag AND interrupt enable) |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
Register writes take effect on the edge that samples them. Read data shows up one edge after the read strobe and carries the value from before that edge. An expiry flag and its interrupt rise exactly (compare + 1) × (divide + 1) edges after the starting write. The bench drives every access on falling edges, keeps its own edge count from each starting write, and samples interrupts on the falling edge just before and just after the predicted expiry edge. Its monitor pairs each read response with the expected word that the driver queued for it, and compares one cycle after the strobe, so that count readbacks are checked against the stepping formula at known edge offsets.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  localparam int CTRL_EN_BIT   = 30;
  localparam int CTRL_IE_BIT   = 29;
  localparam int CTRL_MODE_LSB = 27;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_ALT2     = 2'b10,
    MODE_ALT3     = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      en;
    logic      ie;
    tmr_mode_e mode;
  } ctrl_t;

endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] div,
  output logic            tick
);

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] ps_d;
  logic            ps_ce;

  // A tick ends a span of div+1 clocks; >= guards against a divide value lowered mid-span
  assign tick = run && !restart && (ps_q >= div);

  always_comb begin
    ps_ce = restart | run;
    if (restart || tick) ps_d = '0;
    else                 ps_d = ps_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ps_q <= '0;
    else if (ps_ce) ps_q <= ps_d;
  end

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ps_q == '0));

endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             periodic,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign expire = tick && (cnt_q == '0);
  assign cnt    = cnt_q;

  always_comb begin
    cnt_ce = load | tick;
    if (load)        cnt_d = cmp;
    else if (expire) cnt_d = periodic ? cmp : '0;
    else if (tick)   cnt_d = cnt_q - CNT_W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic && !load) |=> (cnt_q == $past(cmp)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/ptimer_channel.sv
module ptimer_channel
  import ptimer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PS_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] cmp_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic              ie,
  output logic              expire
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [PS_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt;
  logic             ctrl_ce;
  logic             start;
  logic             periodic;
  logic             tick;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;
  assign periodic     = (ctrl_q.mode == MODE_PERIODIC);
  assign start        = wr_ctrl && wdata[CTRL_EN_BIT] && !ctrl_q.en;

  always_comb begin
    ctrl_d  = ctrl_q;
    div_d   = div_q;
    ctrl_ce = wr_ctrl | (expire & !periodic);
    if (wr_ctrl) begin
      ctrl_d.en   = wdata[CTRL_EN_BIT];
      ctrl_d.ie   = wdata[CTRL_IE_BIT];
      ctrl_d.mode = tmr_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
      div_d       = wdata[PS_W-1:0];
    end else if (expire && !periodic) begin
      ctrl_d.en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
  end

  ptimer_prescaler #(.PS_W(PS_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.en),
    .restart (start),
    .div     (div_q),
    .tick    (tick)
  );

  ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (start),
    .periodic (periodic),
    .cmp      (cmp_q),
    .cnt      (cnt),
    .expire   (expire)
  );

  always_comb begin
    ctrl_rd                          = '0;
    ctrl_rd[CTRL_EN_BIT]             = ctrl_q.en;
    ctrl_rd[CTRL_IE_BIT]             = ctrl_q.ie;
    ctrl_rd[CTRL_MODE_LSB +: 2]      = ctrl_q.mode;
    ctrl_rd[PS_W-1:0]                = div_q;
  end

  assign cmp_rd = DATA_W'(cmp_q);
  assign cnt_rd = DATA_W'(cnt);
  assign ie     = ctrl_q.ie;

  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic && !wr_ctrl) |=> !ctrl_q.en);

endmodule

// File: rtl/ptimer_status.sv
module ptimer_status #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] flags
);

  logic [NUM_CH-1:0] flags_q;
  logic [NUM_CH-1:0] flags_d;
  logic              flags_ce;

  always_comb begin
    flags_ce = (|set) | (|clr);
    flags_d  = (flags_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_ce) flags_q <= flags_d;
  end

  assign flags = flags_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags_q & $past(set)) == $past(set)));

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set[i]) |=> !flags_q[i]);
    end
  endgenerate

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 24,
  parameter int PS_W   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] chan_irq,
  output logic              irq_any
);

  localparam int REGS_PER_CH = 4;
  localparam int STAT_ADDR   = NUM_CH * REGS_PER_CH;

  logic [DATA_W-1:0] ctrl_rd [NUM_CH];
  logic [DATA_W-1:0] cmp_rd  [NUM_CH];
  logic [DATA_W-1:0] cnt_rd  [NUM_CH];
  logic [NUM_CH-1:0] ie_vec;
  logic [NUM_CH-1:0] expire_vec;
  logic [NUM_CH-1:0] stat_clr;
  logic [NUM_CH-1:0] flags;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic              stat_sel;

  assign stat_sel = (bus_addr == ADDR_W'(STAT_ADDR));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic wr_ctrl_g;
      logic wr_cmp_g;
      assign wr_ctrl_g = bus_wr && (bus_addr == ADDR_W'(g * REGS_PER_CH));
      assign wr_cmp_g  = bus_wr && (bus_addr == ADDR_W'(g * REGS_PER_CH + 1));

      ptimer_channel #(
        .CNT_W  (CNT_W),
        .PS_W   (PS_W),
        .DATA_W (DATA_W)
      ) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl_g),
        .wr_cmp  (wr_cmp_g),
        .wdata   (bus_wdata),
        .ctrl_rd (ctrl_rd[g]),
        .cmp_rd  (cmp_rd[g]),
        .cnt_rd  (cnt_rd[g]),
        .ie      (ie_vec[g]),
        .expire  (expire_vec[g])
      );

      p_flag_on_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_vec[g] |=> flags[g]);
    end
  endgenerate

  assign stat_clr = (bus_wr && stat_sel) ? bus_wdata[NUM_CH-1:0] : '0;

  ptimer_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire_vec),
    .clr   (stat_clr),
    .flags (flags)
  );

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(c * REGS_PER_CH))     rdata_d = ctrl_rd[c];
      if (bus_addr == ADDR_W'(c * REGS_PER_CH + 1)) rdata_d = cmp_rd[c];
      if (bus_addr == ADDR_W'(c * REGS_PER_CH + 2)) rdata_d = cnt_rd[c];
    end
    if (stat_sel) rdata_d = DATA_W'(flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign chan_irq  = flags & ie_vec;
  assign irq_any   = |chan_irq;

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/ptimer_top_bench.sv
`timescale 1ns/100ps
module ptimer_top_bench;

  localparam int NUM_CH = 2;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr;
  logic              bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_CH-1:0] chan_irq;
  logic              irq_any;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic  rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  ptimer_top u_ptimer_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .chan_irq  (chan_irq),
    .irq_any   (irq_any)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read strobe seen on an edge has its data checked on the following falling edge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) chk("R11 unexpected response", bus_rdata, 32'h0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  function automatic logic [31:0] cw(bit en, bit ie, logic [1:0] mode, logic [7:0] ps);
    return {1'b0, en, ie, mode, 19'b0, ps};
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 chan_irq", 32'(chan_irq), 32'h0);
    chk("R1 irq_any", 32'(irq_any), 32'h0);
    rd(4'd0, 32'h0, "R1 ctrl0");
    rd(4'd2, 32'h0, "R1 count0");
    rd(4'd5, 32'h0, "R1 compare1");
    rd(4'd8, 32'h0, "R1 status");

    // R3 24-bit compare, R11 unmapped reads
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h00FF_FFFF, "R3 compare width");
    rd(4'd3, 32'h0, "R11 unmapped 3");
    rd(4'd15, 32'h0, "R11 unmapped 15");
    wr(4'd1, 32'd3);

    // R2 field positions; stray bits dropped, enable low does not start
    wr(4'd0, cw(0, 1, 2'b01, 8'h01) | 32'h8000_FF00);
    rd(4'd0, cw(0, 1, 2'b01, 8'h01), "R2 ctrl readback");
    rd(4'd2, 32'h0, "R2 enable low keeps count");

    // R4/R5/R6: compare 3, divide 1, periodic; start edge k, expiry at k+8
    wr(4'd0, cw(1, 1, 2'b01, 8'h01));
    for (int m = 1; m <= 5; m++)
      rd(4'd2, 32'(3 - (m - 1) / 2), "R4 count stepping");
    idle(2);
    chk("R5 irq before expiry", 32'(chan_irq[0]), 32'h0);
    idle(1);
    chk("R5 irq at expiry", 32'(chan_irq[0]), 32'h1);
    chk("R10 irq_any", 32'(irq_any), 32'h1);
    rd(4'd2, 32'd3, "R6 reload after expiry");
    // R8: stop at edge k+10, the tick on that edge leaves count 2
    wr(4'd0, cw(0, 1, 2'b00, 8'h01));
    idle(6);
    rd(4'd2, 32'd2, "R8 count holds");
    rd(4'd2, 32'd2, "R8 count still holds");

    // R9 write-1-to-clear
    rd(4'd8, 32'h1, "R9 flag pending");
    wr(4'd8, 32'h0);
    rd(4'd8, 32'h1, "R9 writing 0 ignored");
    chk("R9 irq after write 0", 32'(chan_irq[0]), 32'h1);
    wr(4'd8, 32'h1);
    rd(4'd8, 32'h0, "R9 cleared");
    chk("R9 irq after clear", 32'(irq_any), 32'h0);

    // R7/R10: channel 1 one-shot, interrupt disabled, compare 2, divide 0 -> expiry at k+3
    wr(4'd5, 32'd2);
    wr(4'd4, cw(1, 0, 2'b00, 8'h00));
    idle(2);
    rd(4'd8, 32'h0, "R5 flag not yet set");
    rd(4'd8, 32'h2, "R5 flag set on channel 1 bit");
    chk("R10 gated irq", 32'(chan_irq), 32'h0);
    chk("R10 gated irq_any", 32'(irq_any), 32'h0);
    rd(4'd4, 32'h0, "R7 enable self-cleared");
    rd(4'd6, 32'h0, "R7 count rests at 0");
    wr(4'd4, cw(0, 1, 2'b00, 8'h00));
    chk("R10 late enable raises irq", 32'(chan_irq), 32'h2);
    chk("R10 irq_any follows", 32'(irq_any), 32'h1);
    wr(4'd8, 32'h2);
    idle(20);
    rd(4'd8, 32'h0, "R7 fires once");
    rd(4'd6, 32'h0, "R7 count stays 0");

    // R9 set wins: channel 1 periodic with compare 0, divide 0 expires every edge
    wr(4'd5, 32'd0);
    wr(4'd4, cw(1, 0, 2'b01, 8'h00));
    idle(2);
    wr(4'd8, 32'h2);
    rd(4'd8, 32'h2, "R9 set wins over clear");
    wr(4'd4, 32'h0);
    wr(4'd8, 32'h2);
    rd(4'd8, 32'h0, "R9 clear after stop");

    // R4/R6: channel 0 compare 0, divide 4, periodic -> expiries at k+5, k+10
    wr(4'd1, 32'd0);
    wr(4'd0, cw(1, 1, 2'b01, 8'h04));
    idle(4);
    chk("R4 divide 4 before tick", 32'(chan_irq[0]), 32'h0);
    idle(1);
    chk("R4 divide 4 expiry", 32'(chan_irq[0]), 32'h1);
    wr(4'd8, 32'h1);
    chk("R9 cleared between periods", 32'(chan_irq[0]), 32'h0);
    idle(3);
    chk("R6 no early second expiry", 32'(chan_irq[0]), 32'h0);
    idle(1);
    chk("R6 second expiry", 32'(chan_irq[0]), 32'h1);
    wr(4'd0, 32'h0);

    idle(3);
    summary();
  end

endmodule